// File: doc/BRIEF.md
# Cycle Counter with Split-Read Consistency Flag

This block is a per-core 64-bit cycle counter that software sees as three 32-bit auxiliary registers: a control word, the lower half of the count and the upper half of the count. The counter advances by one on every clock while counting is enabled. It never copies its value into a snapshot register. Software reads the lower half, then the upper half, then the control word. Bit 31 of the control word reports whether that two-read pair gives a consistent 64-bit value. If it does not, software repeats the sequence.

A small tracker watches the order of reads. A lower-half read opens a window and discards any earlier verdict. Two things spoil the window: an event pulse, which marks an interrupt or exception taken by the core, and a carry into the upper half. A carry happens when the lower half rolls from all ones to zero. An upper-half read closes the window and records the verdict. An upper-half read with no open window always gives a failed verdict. The two count halves can also be written, which lets the count be preset to any value.

Top module: `cyc64_counter`

## Requirements
- R1: After reset the count is zero, counting is disabled and control bit 31 reads 0.
- R2: A write to the control address (default 0x103) sets the enable from write-data bit 0. Control reads return the enable in bit 0, the verdict in bit 31 and zeros in bits 30 to 1.
- R3: While enabled, the 64-bit count rises by one per clock, and the lower half carries into the upper half. The lower half reads at address 0x104 and the upper half at 0x105, in the cycle the read strobe is high.
- R4: While disabled, the count holds its value.
- R5: A write to the lower-half address loads that half, and the upper half does not change in that cycle. A write to the upper-half address loads that half while the lower half keeps counting.
- R6: A lower read followed by an upper read gives control bit 31 = 1 when nothing spoils the window in between.
- R7: An event pulse spoils the window and gives bit 31 = 0. This holds for a pulse in any cycle from the lower read up to, but not including, the upper read.
- R8: A carry into the upper half also spoils the window and gives bit 31 = 0. This holds for a carry at any clock edge from the lower read's edge up to, but not including, the upper read's edge.
- R9: An upper read with no open window gives bit 31 = 0.
- R10: A lower read clears bit 31 to 0, opens a fresh window and forgets any earlier failure.
- R11: A read of any other address, or a cycle with no read strobe, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_rd | input | 1 | Register read strobe |
| aux_wr | input | 1 | Register write strobe |
| aux_addr | input | 12 | Register address |
| aux_wdata | input | 32 | Write data |
| aux_rdata | output | 32 | Read data, valid in the cycle of aux_rd |
| evt_taken | input | 1 | One-cycle pulse: interrupt or exception taken |

## Verification
Directed sequences cover four kinds of read pair: a clean pair, a pair with an event pulse inside the window, a pair in which the lower half is preset just below the wrap so that a carry lands inside the window, and an upper read with no lower read before it. Comparing their verdicts shows that each failure cause is detected on its own and that a clean pair passes. A constrained-random run then mixes reads in any order, occasional presets close to the wrap point, enable toggles and sparse event pulses. This exercises the window edges: a carry or event on the lower-read cycle, on the upper-read cycle, and a lower read that reopens a window already spoiled.

// File: rtl/cyc64_pkg.sv
package cyc64_pkg;

  // decoded register strobes, one bit per access kind
  typedef struct packed {
    logic rd_ctl;
    logic rd_lo;
    logic rd_hi;
    logic wr_ctl;
    logic wr_lo;
    logic wr_hi;
  } aux_sel_t;

endpackage

// File: rtl/cyc64_decode.sv
module cyc64_decode
  import cyc64_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 'h103,
  parameter logic [ADDR_W-1:0] LO_ADDR  = 'h104,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 'h105
) (
  input  logic              aux_rd,
  input  logic              aux_wr,
  input  logic [ADDR_W-1:0] aux_addr,
  output aux_sel_t          sel
);

  logic hit_ctl, hit_lo, hit_hi;

  always_comb begin
    hit_ctl    = (aux_addr == CTL_ADDR);
    hit_lo     = (aux_addr == LO_ADDR);
    hit_hi     = (aux_addr == HI_ADDR);
    sel.rd_ctl = aux_rd & hit_ctl;
    sel.rd_lo  = aux_rd & hit_lo;
    sel.rd_hi  = aux_rd & hit_hi;
    sel.wr_ctl = aux_wr & hit_ctl;
    sel.wr_lo  = aux_wr & hit_lo;
    sel.wr_hi  = aux_wr & hit_hi;
  end

endmodule

// File: rtl/cyc64_count.sv
module cyc64_count #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [HALF_W-1:0] ld_val,
  output logic [HALF_W-1:0] lo_q,
  output logic [HALF_W-1:0] hi_q,
  output logic              carry_o
);

  logic [HALF_W-1:0] lo_d, hi_d;
  logic              lo_full;
  logic              hi_step;

  always_comb begin
    lo_full = &lo_q;
    // upper half steps only on a wrap that no load overrides
    hi_step = run & lo_full & ~ld_lo;
    carry_o = hi_step & ~ld_hi;

    if (ld_lo)    lo_d = ld_val;
    else if (run) lo_d = lo_q + 1'b1;
    else          lo_d = lo_q;

    if (ld_hi)        hi_d = ld_val;
    else if (hi_step) hi_d = hi_q + 1'b1;
    else              hi_d = hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (ld_lo | run)   lo_q <= lo_d;
      if (ld_hi | hi_step) hi_q <= hi_d;
    end
  end

endmodule

// File: rtl/cyc64_track.sv
module cyc64_track (
  input  logic clk,
  input  logic rst_n,
  input  logic open_i,   // lower-half read
  input  logic close_i,  // upper-half read
  input  logic carry_i,  // upper half incremented at this edge
  input  logic evt_i,    // interrupt or exception taken
  output logic armed_o,
  output logic fail_o,
  output logic ok_o
);

  logic armed_d, fail_d, ok_d;
  logic spoil;

  always_comb begin
    spoil   = carry_i | evt_i;
    armed_d = armed_o;
    fail_d  = fail_o;
    ok_d    = ok_o;
    if (open_i) begin
      armed_d = 1'b1;
      fail_d  = spoil;
      ok_d    = 1'b0;
    end else if (close_i) begin
      armed_d = 1'b0;
      fail_d  = 1'b0;
      ok_d    = armed_o & ~fail_o;
    end else if (armed_o) begin
      fail_d  = fail_o | spoil;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_o <= 1'b0;
      fail_o  <= 1'b0;
      ok_o    <= 1'b0;
    end else begin
      armed_o <= armed_d;
      fail_o  <= fail_d;
      ok_o    <= ok_d;
    end
  end

endmodule

// File: rtl/cyc64_counter.sv
module cyc64_counter
  import cyc64_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter int                HALF_W   = 32,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 'h103,
  parameter logic [ADDR_W-1:0] LO_ADDR  = 'h104,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 'h105
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aux_rd,
  input  logic              aux_wr,
  input  logic [ADDR_W-1:0] aux_addr,
  input  logic [HALF_W-1:0] aux_wdata,
  output logic [HALF_W-1:0] aux_rdata,
  input  logic              evt_taken
);

  localparam int PAD_W = HALF_W - 2;

  aux_sel_t          sel;
  logic              en_q, en_d;
  logic [HALF_W-1:0] cnt_lo, cnt_hi;
  logic              carry;
  logic              trk_armed, trk_fail, stat_ok;

  cyc64_decode #(
    .ADDR_W  (ADDR_W),
    .CTL_ADDR(CTL_ADDR),
    .LO_ADDR (LO_ADDR),
    .HI_ADDR (HI_ADDR)
  ) u_dec (
    .aux_rd  (aux_rd),
    .aux_wr  (aux_wr),
    .aux_addr(aux_addr),
    .sel     (sel)
  );

  cyc64_count #(.HALF_W(HALF_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (en_q),
    .ld_lo  (sel.wr_lo),
    .ld_hi  (sel.wr_hi),
    .ld_val (aux_wdata),
    .lo_q   (cnt_lo),
    .hi_q   (cnt_hi),
    .carry_o(carry)
  );

  cyc64_track u_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .open_i (sel.rd_lo),
    .close_i(sel.rd_hi),
    .carry_i(carry),
    .evt_i  (evt_taken),
    .armed_o(trk_armed),
    .fail_o (trk_fail),
    .ok_o   (stat_ok)
  );

  always_comb begin
    en_d = sel.wr_ctl ? aux_wdata[0] : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (sel.wr_ctl) en_q <= en_d;
  end

  always_comb begin
    aux_rdata = '0;
    if (sel.rd_ctl)     aux_rdata = {stat_ok, {PAD_W{1'b0}}, en_q};
    else if (sel.rd_lo) aux_rdata = cnt_lo;
    else if (sel.rd_hi) aux_rdata = cnt_hi;
  end

endmodule

// File: rtl/cyc64_counter_chk.sv
module cyc64_counter_chk #(
  parameter int                ADDR_W   = 12,
  parameter int                HALF_W   = 32,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 'h103,
  parameter logic [ADDR_W-1:0] LO_ADDR  = 'h104,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 'h105
) (
  input logic              clk,
  input logic              rst_n,
  input logic              aux_rd,
  input logic              aux_wr,
  input logic [ADDR_W-1:0] aux_addr,
  input logic [HALF_W-1:0] aux_wdata,
  input logic              evt_taken,
  input logic              en_q,
  input logic [HALF_W-1:0] cnt_lo,
  input logic [HALF_W-1:0] cnt_hi,
  input logic              trk_armed,
  input logic              trk_fail,
  input logic              stat_ok
);

  logic rd_lo_c, rd_hi_c, wr_ctl_c;
  assign rd_lo_c  = aux_rd && (aux_addr == LO_ADDR);
  assign rd_hi_c  = aux_rd && (aux_addr == HI_ADDR);
  assign wr_ctl_c = aux_wr && (aux_addr == CTL_ADDR);

  // R2
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl_c |=> (en_q == $past(aux_wdata[0])));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !aux_wr) |=> ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + 1'b1));

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !aux_wr) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  // R7
  evt_spoil_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_armed && evt_taken && !rd_hi_c) |=> trk_fail);

  // R9
  orphan_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi_c && !trk_armed) |=> !stat_ok);

  // R10
  low_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo_c |=> (trk_armed && !stat_ok));

endmodule

bind cyc64_counter cyc64_counter_chk #(
  .ADDR_W  (ADDR_W),
  .HALF_W  (HALF_W),
  .CTL_ADDR(CTL_ADDR),
  .LO_ADDR (LO_ADDR),
  .HI_ADDR (HI_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .aux_rd   (aux_rd),
  .aux_wr   (aux_wr),
  .aux_addr (aux_addr),
  .aux_wdata(aux_wdata),
  .evt_taken(evt_taken),
  .en_q     (en_q),
  .cnt_lo   (cnt_lo),
  .cnt_hi   (cnt_hi),
  .trk_armed(trk_armed),
  .trk_fail (trk_fail),
  .stat_ok  (stat_ok)
);

// File: tb/test_cyc64_counter.sv
module test_cyc64_counter;

  localparam int CLK_P = 10;
  localparam logic [11:0] A_CTL = 12'h103;
  localparam logic [11:0] A_LO  = 12'h104;
  localparam logic [11:0] A_HI  = 12'h105;

  logic        clk;
  logic        rst_n;
  logic        aux_rd, aux_wr, evt_taken;
  logic [11:0] aux_addr;
  logic [31:0] aux_wdata, aux_rdata;

  int n_tests, n_fail;

  // bench reference state, derived from the requirements
  logic [63:0] m_cnt;
  logic        m_en, m_armed, m_fail, m_ok;
  logic [31:0] last_rd;

  cyc64_counter i_cyc64_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .aux_rd   (aux_rd),
    .aux_wr   (aux_wr),
    .aux_addr (aux_addr),
    .aux_wdata(aux_wdata),
    .aux_rdata(aux_rdata),
    .evt_taken(evt_taken)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] exp_read(logic [11:0] a);
    if (a == A_CTL) return {m_ok, 30'd0, m_en};
    if (a == A_LO)  return m_cnt[31:0];
    if (a == A_HI)  return m_cnt[63:32];
    return 32'd0;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_edge(logic rd, logic wr, logic [11:0] a,
                            logic [31:0] wd, logic ev);
    logic wlo, whi, rlo, rhi, carry, spoil;
    wlo   = wr && a == A_LO;
    whi   = wr && a == A_HI;
    rlo   = rd && a == A_LO;
    rhi   = rd && a == A_HI;
    carry = m_en && (&m_cnt[31:0]) && !wlo && !whi;
    spoil = carry || ev;
    if (rlo) begin
      m_armed = 1'b1; m_fail = spoil; m_ok = 1'b0;
    end else if (rhi) begin
      m_ok = m_armed && !m_fail; m_armed = 1'b0; m_fail = 1'b0;
    end else if (m_armed) begin
      m_fail = m_fail || spoil;
    end
    if (wlo)      m_cnt[31:0]  = wd;
    else if (whi) begin
      m_cnt[63:32] = wd;
      if (m_en) m_cnt[31:0] = m_cnt[31:0] + 32'd1;
    end else if (m_en) m_cnt = m_cnt + 64'd1;
    if (wr && a == A_CTL) m_en = wd[0];
  endtask

  // one bus cycle: drive at the falling edge, sample before the rising edge
  task automatic step(string req, logic rd, logic wr, logic [11:0] a,
                      logic [31:0] wd, logic ev);
    @(negedge clk);
    aux_rd = rd; aux_wr = wr; aux_addr = a; aux_wdata = wd; evt_taken = ev;
    #1;
    last_rd = aux_rdata;
    check(req, aux_rdata, rd ? exp_read(a) : 32'd0);
    @(posedge clk);
    model_edge(rd, wr, a, wd, ev);
  endtask

  task automatic rd_reg(string req, logic [11:0] a);
    step(req, 1'b1, 1'b0, a, 32'd0, 1'b0);
  endtask
  task automatic wr_reg(string req, logic [11:0] a, logic [31:0] d);
    step(req, 1'b0, 1'b1, a, d, 1'b0);
  endtask
  task automatic idle(string req, logic ev);
    step(req, 1'b0, 1'b0, 12'h000, 32'd0, ev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v0;
    n_tests = 0; n_fail = 0;
    m_cnt = '0; m_en = 0; m_armed = 0; m_fail = 0; m_ok = 0;
    aux_rd = 0; aux_wr = 0; aux_addr = '0; aux_wdata = '0; evt_taken = 0;
    rst_n = 0;
    void'($urandom(32'd20161215));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset values
    rd_reg("R1", A_CTL); check("R1", last_rd, 32'h0000_0000);
    rd_reg("R1", A_LO);  check("R1", last_rd, 32'h0000_0000);
    rd_reg("R1", A_HI);  check("R1", last_rd, 32'h0000_0000);
    // R4 disabled: still zero
    idle("R4", 1'b0);
    rd_reg("R4", A_LO);  check("R4", last_rd, 32'h0000_0000);

    // R2 enable and read back
    wr_reg("R2", A_CTL, 32'h0000_0001);
    rd_reg("R2", A_CTL); check("R2", last_rd, 32'h0000_0001);

    // R3 count advances
    rd_reg("R3", A_LO); v0 = last_rd;
    idle("R3", 1'b0); idle("R3", 1'b0);
    rd_reg("R3", A_LO); check("R3", last_rd, v0 + 32'd3);

    // R6 clean pair
    rd_reg("R6", A_LO); rd_reg("R6", A_HI);
    rd_reg("R6", A_CTL); check("R6", last_rd, 32'h8000_0001);

    // R7 event inside window
    rd_reg("R7", A_LO); idle("R7", 1'b1); rd_reg("R7", A_HI);
    rd_reg("R7", A_CTL); check("R7", last_rd, 32'h0000_0001);

    // R7 event on the upper-read cycle does not spoil
    rd_reg("R7", A_LO);
    step("R7", 1'b1, 1'b0, A_HI, 32'd0, 1'b1);
    rd_reg("R7", A_CTL); check("R7", last_rd, 32'h8000_0001);

    // R10 earlier failure forgotten by a new lower read
    rd_reg("R10", A_LO); idle("R10", 1'b1);
    rd_reg("R10", A_LO);
    rd_reg("R10", A_CTL); check("R10", last_rd, 32'h0000_0001);
    rd_reg("R10", A_HI);
    rd_reg("R10", A_CTL); check("R10", last_rd, 32'h8000_0001);

    // R5 preset low near wrap, R8 carry inside window
    wr_reg("R5", A_LO, 32'hFFFF_FFFD);
    rd_reg("R5", A_LO); check("R5", last_rd, 32'hFFFF_FFFD);
    v0 = m_cnt[63:32];
    idle("R8", 1'b0); idle("R8", 1'b0);
    rd_reg("R8", A_HI); check("R8", last_rd, v0 + 32'd1);
    rd_reg("R8", A_CTL); check("R8", last_rd, 32'h0000_0001);

    // R9 upper read without a lower read
    rd_reg("R9", A_HI);
    rd_reg("R9", A_CTL); check("R9", last_rd, 32'h0000_0001);

    // R5 upper preset while lower keeps counting
    wr_reg("R5", A_HI, 32'h1234_5678);
    rd_reg("R5", A_HI); check("R5", last_rd, 32'h1234_5678);

    // R4 stop counting
    wr_reg("R4", A_CTL, 32'h0000_0000);
    rd_reg("R4", A_LO); v0 = last_rd;
    idle("R4", 1'b0); idle("R4", 1'b0);
    rd_reg("R4", A_LO); check("R4", last_rd, v0);
    wr_reg("R4", A_CTL, 32'h0000_0001);

    // R11 unmapped address and write cycle read zero
    rd_reg("R11", 12'h106); check("R11", last_rd, 32'd0);
    wr_reg("R11", 12'h0FF, 32'hDEAD_BEEF);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned op;
      logic ev;
      logic [31:0] d;
      op = $urandom % 16;
      ev = ($urandom % 10) == 0;
      if (op < 4)        step("R3", 1'b1, 1'b0, A_LO, 32'd0, ev);
      else if (op < 8)   step("R3", 1'b1, 1'b0, A_HI, 32'd0, ev);
      else if (op < 11)  step("R6", 1'b1, 1'b0, A_CTL, 32'd0, ev);
      else if (op == 11) begin
        d = ($urandom % 2) ? (32'hFFFF_FFF0 | ($urandom % 16)) : $urandom;
        step("R5", 1'b0, 1'b1, A_LO, d, ev);
      end else if (op == 12) step("R5", 1'b0, 1'b1, A_HI, $urandom, ev);
      else if (op == 13) begin
        d = (($urandom % 8) != 0) ? 32'd1 : 32'd0;
        step("R2", 1'b0, 1'b1, A_CTL, d, ev);
      end else step("R11", 1'b0, 1'b0, 12'h000, 32'd0, ev);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule